// File: doc/BRIEF.md
# Processor Status Flags Register

This block holds the status and control flags of a simple processor core as a 64-bit architectural register. Seven programmable flags sit at fixed bit positions in the low half-word: six that report arithmetic results (carry, parity, half-carry, zero, sign, overflow) and one control flag that steers the direction of string stepping. Sixteen more bits, 31 to 16, hold system state that only privileged accesses may change. The rest of the word is fixed: bit 1 always reads one, the other gaps in the low half-word read zero, and the top 32 bits read zero whatever is written there.

Two sources update the register. The execution unit presents a new value for each flag together with a 7-bit enable mask, and only the enabled flags change. Software writes the whole register in one access. When both arrive in the same cycle, the software write wins and the execution unit's update is dropped for that cycle. A 2-bit mode input picks how wide the architectural view is, for both reads and writes: 16, 32 or 64 bits. The read port is combinational from the stored state and the current mode.

Top module: `cpu_status_flags`

## Requirements
- R1: `flag_vec_o` reports the flags in the order bit0 carry, bit1 parity, bit2 half-carry, bit3 zero, bit4 sign, bit5 direction, bit6 overflow, and `rd_data_o` places them at bit positions 0, 2, 4, 6, 7, 10 and 11 respectively.
- R2: A cycle with `rst` high (synchronous, active high) clears all seven flags and bits 31 to 16, so the register reads 0x2 in every mode.
- R3: `rd_data_o[63:32]` always reads zero, and software write data in bits 63 to 32 has no effect on any later read.
- R4: Bit 1 always reads one and bits 3, 5, 8, 9 and 12 to 15 always read zero, whatever is written to them.
- R5: `mode_i` 00 selects the 16-bit view, where reads return bits 15 to 0 zero-extended; 01 selects the 32-bit view, where reads return bits 31 to 0 zero-extended; 10 and 11 select the full 64-bit view.
- R6: A software write made in the 16-bit view leaves bits 31 to 16 unchanged, even when privileged.
- R7: Bits 31 to 16 change only on a software write with `priv_i` high in the 32-bit or 64-bit view; unprivileged writes leave them unchanged while still updating the flags.
- R8: With no software write, each flag whose bit in `alu_en_i` is one takes the matching bit of `alu_flags_i` at the clock edge, and every other flag keeps its value; both vectors use the R1 bit order.
- R9: When `sw_we_i` and a nonzero `alu_en_i` occur in the same cycle, the flags take the software write data and the execution-unit update is discarded.
- R10: Every update becomes visible on `rd_data_o` and `flag_vec_o` in the cycle after the clock edge that samples it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_i | input | 2 | Access width: 00 16-bit, 01 32-bit, 1x 64-bit |
| priv_i | input | 1 | Software access is privileged |
| sw_we_i | input | 1 | Software whole-register write strobe |
| sw_wdata_i | input | 64 | Software write data |
| alu_en_i | input | 7 | Per-flag update enable from the execution unit |
| alu_flags_i | input | 7 | New flag values from the execution unit |
| rd_data_o | output | 64 | Register read data in the selected view |
| flag_vec_o | output | 7 | Current flags, compact form |

## Verification
Directed software writes of all-ones and all-zeros data separate the programmable flag bits from the hardwired ones and from the reserved upper half. Privileged and unprivileged writes are each made in all three views, and afterwards the register is read back in the 32-bit view, so a leak into the system bits shows up. Walking single-bit enables on the execution-unit port and fully masked updates check which flags change and which hold. Same-cycle software and execution-unit traffic, followed by a long pseudo-random mix of modes, privilege, enables and data, checks the priority rule against the bench model on every cycle.

// File: rtl/sflag_pkg.sv
package sflag_pkg;

    localparam int REG_W  = 64;
    localparam int LOW_W  = 16;
    localparam int MID_W  = 32;
    localparam int SYS_W  = MID_W - LOW_W;
    localparam int FLAG_N = 7;

    // Bits of the low half-word that read as constant one.
    localparam logic [LOW_W-1:0] LOW_ONES = 16'h0002;

    typedef enum logic [1:0] {
        VIEW_W16  = 2'b00,
        VIEW_W32  = 2'b01,
        VIEW_W64  = 2'b10,
        VIEW_W64B = 2'b11
    } view_e;

    // Packed so that bit 0 is carry and bit 6 is overflow.
    typedef struct packed {
        logic ovf;
        logic dir;
        logic sgn;
        logic zro;
        logic hcy;
        logic par;
        logic cry;
    } flags_t;

    typedef struct packed {
        logic              we;
        logic              priv;
        view_e             view;
        logic [MID_W-1:0]  data;
    } sw_req_t;

    typedef struct packed {
        flags_t en;
        flags_t val;
    } alu_upd_t;

    // Position of compact flag idx inside the architectural word.
    function automatic int flag_pos(input int idx);
        case (idx)
            0:       return 0;
            1:       return 2;
            2:       return 4;
            3:       return 6;
            4:       return 7;
            5:       return 10;
            default: return 11;
        endcase
    endfunction

    function automatic flags_t pick_flags(input logic [LOW_W-1:0] w);
        logic [FLAG_N-1:0] v;
        for (int i = 0; i < FLAG_N; i++) begin
            v[i] = w[flag_pos(i)];
        end
        return flags_t'(v);
    endfunction

    function automatic logic [LOW_W-1:0] place_flags(input flags_t f);
        logic [FLAG_N-1:0] v;
        logic [LOW_W-1:0]  w;
        v = f;
        w = LOW_ONES;
        for (int i = 0; i < FLAG_N; i++) begin
            w[flag_pos(i)] = v[i];
        end
        return w;
    endfunction

    function automatic int view_width(input view_e m);
        return (m == VIEW_W16) ? LOW_W : MID_W;
    endfunction

    function automatic logic [REG_W-1:0] view_mask(input view_e m);
        logic [REG_W-1:0] k;
        for (int b = 0; b < REG_W; b++) begin
            k[b] = (b < view_width(m));
        end
        return k;
    endfunction

    function automatic logic sys_writable(input view_e m);
        return m != VIEW_W16;
    endfunction

endpackage

// File: rtl/sflag_next.sv
module sflag_next
    import sflag_pkg::*;
(
    input  sw_req_t            sw,
    input  alu_upd_t           alu,
    output flags_t             nxt_flags,
    output logic [FLAG_N-1:0]  flag_ld,
    output logic [SYS_W-1:0]   nxt_sys,
    output logic               sys_ld
);

    always_comb begin
        if (sw.we) begin
            nxt_flags = pick_flags(sw.data[LOW_W-1:0]);
            flag_ld   = '1;
        end else begin
            nxt_flags = alu.val;
            flag_ld   = alu.en;
        end
    end

    always_comb begin
        sys_ld  = sw.we && sw.priv && sys_writable(sw.view);
        nxt_sys = sw.data[MID_W-1:LOW_W];
    end

endmodule

// File: rtl/sflag_store.sv
module sflag_store
    import sflag_pkg::*;
#(
    parameter logic [SYS_W-1:0] SYS_RESET = '0
) (
    input  logic               clk,
    input  logic               rst,
    input  flags_t             nxt_flags,
    input  logic [FLAG_N-1:0]  flag_ld,
    input  logic [SYS_W-1:0]   nxt_sys,
    input  logic               sys_ld,
    output flags_t             flags_q,
    output logic [SYS_W-1:0]   sys_q
);

    logic [FLAG_N-1:0] bits_q;
    logic [FLAG_N-1:0] bits_d;

    assign bits_d = nxt_flags;

    always_ff @(posedge clk) begin
        if (rst) begin
            bits_q <= '0;
        end else begin
            for (int i = 0; i < FLAG_N; i++) begin
                if (flag_ld[i]) begin
                    bits_q[i] <= bits_d[i];
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sys_q <= SYS_RESET;
        end else if (sys_ld) begin
            sys_q <= nxt_sys;
        end
    end

    assign flags_q = flags_t'(bits_q);

endmodule

// File: rtl/sflag_view.sv
module sflag_view
    import sflag_pkg::*;
(
    input  flags_t             flags_q,
    input  logic [SYS_W-1:0]   sys_q,
    input  view_e              view,
    output logic [REG_W-1:0]   rd_data,
    output logic [FLAG_N-1:0]  flag_vec
);

    logic [REG_W-1:0] image;

    always_comb begin
        image   = {{(REG_W-MID_W){1'b0}}, sys_q, place_flags(flags_q)};
        rd_data = image & view_mask(view);
    end

    assign flag_vec = flags_q;

endmodule

// File: rtl/cpu_status_flags.sv
module cpu_status_flags
    import sflag_pkg::*;
#(
    parameter logic [SYS_W-1:0] SYS_RESET = '0
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [1:0]         mode_i,
    input  logic               priv_i,
    input  logic               sw_we_i,
    input  logic [REG_W-1:0]   sw_wdata_i,
    input  logic [FLAG_N-1:0]  alu_en_i,
    input  logic [FLAG_N-1:0]  alu_flags_i,
    output logic [REG_W-1:0]   rd_data_o,
    output logic [FLAG_N-1:0]  flag_vec_o
);

    view_e             view;
    sw_req_t           sw;
    alu_upd_t          alu;
    flags_t            nxt_flags;
    logic [FLAG_N-1:0] flag_ld;
    logic [SYS_W-1:0]  nxt_sys;
    logic              sys_ld;
    flags_t            flags_q;
    logic [SYS_W-1:0]  sys_q;
    logic              unused_reserved;

    // Reserved write data is dropped here.
    assign unused_reserved = ^sw_wdata_i[REG_W-1:MID_W];

    assign view = view_e'(mode_i);

    always_comb begin
        sw.we    = sw_we_i;
        sw.priv  = priv_i;
        sw.view  = view;
        sw.data  = sw_wdata_i[MID_W-1:0];
        alu.en   = flags_t'(alu_en_i);
        alu.val  = flags_t'(alu_flags_i);
    end

    sflag_next i_next (
        .sw        (sw),
        .alu       (alu),
        .nxt_flags (nxt_flags),
        .flag_ld   (flag_ld),
        .nxt_sys   (nxt_sys),
        .sys_ld    (sys_ld)
    );

    sflag_store #(
        .SYS_RESET (SYS_RESET)
    ) i_store (
        .clk       (clk),
        .rst       (rst),
        .nxt_flags (nxt_flags),
        .flag_ld   (flag_ld),
        .nxt_sys   (nxt_sys),
        .sys_ld    (sys_ld),
        .flags_q   (flags_q),
        .sys_q     (sys_q)
    );

    sflag_view i_view (
        .flags_q  (flags_q),
        .sys_q    (sys_q),
        .view     (view),
        .rd_data  (rd_data_o),
        .flag_vec (flag_vec_o)
    );

endmodule

// File: rtl/sflag_checker.sv
module sflag_checker (
    input logic        clk,
    input logic        rst,
    input logic [1:0]  mode_i,
    input logic        priv_i,
    input logic        sw_we_i,
    input logic [15:0] wdata_lo,
    input logic [6:0]  alu_en_i,
    input logic [6:0]  alu_flags_i,
    input logic [63:0] rd_data_o,
    input logic [6:0]  flag_vec_o,
    input logic [15:0] sys_q
);

    logic [6:0] w_flags;
    assign w_flags = {wdata_lo[11], wdata_lo[10], wdata_lo[7], wdata_lo[6],
                      wdata_lo[4], wdata_lo[2], wdata_lo[0]};

    assert_flag_layout_R1: assert property (@(posedge clk) disable iff (rst)
        flag_vec_o == {rd_data_o[11], rd_data_o[10], rd_data_o[7], rd_data_o[6],
                       rd_data_o[4], rd_data_o[2], rd_data_o[0]});

    assert_reset_value_R2: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (flag_vec_o == 7'd0 && sys_q == 16'd0));

    assert_upper_zero_R3: assert property (@(posedge clk) disable iff (rst)
        rd_data_o[63:32] == 32'd0);

    assert_fixed_bits_R4: assert property (@(posedge clk) disable iff (rst)
        rd_data_o[1] && !rd_data_o[3] && !rd_data_o[5] && !rd_data_o[8]
        && !rd_data_o[9] && rd_data_o[15:12] == 4'd0);

    assert_narrow_view_R5: assert property (@(posedge clk) disable iff (rst)
        mode_i == 2'b00 |-> rd_data_o[63:16] == 48'd0);

    assert_narrow_write_R6: assert property (@(posedge clk) disable iff (rst)
        (sw_we_i && mode_i == 2'b00) |=> $stable(sys_q));

    assert_sys_guard_R7: assert property (@(posedge clk) disable iff (rst)
        !(sw_we_i && priv_i) |=> $stable(sys_q));

    assert_alu_enabled_R8: assert property (@(posedge clk) disable iff (rst)
        !sw_we_i |=> (flag_vec_o & $past(alu_en_i)) == ($past(alu_flags_i) & $past(alu_en_i)));

    assert_alu_masked_R8: assert property (@(posedge clk) disable iff (rst)
        !sw_we_i |=> (flag_vec_o & ~$past(alu_en_i)) == ($past(flag_vec_o) & ~$past(alu_en_i)));

    assert_sw_priority_R9: assert property (@(posedge clk) disable iff (rst)
        sw_we_i |=> flag_vec_o == $past(w_flags));

endmodule

bind cpu_status_flags sflag_checker i_sflag_checker (
    .clk         (clk),
    .rst         (rst),
    .mode_i      (mode_i),
    .priv_i      (priv_i),
    .sw_we_i     (sw_we_i),
    .wdata_lo    (sw_wdata_i[15:0]),
    .alu_en_i    (alu_en_i),
    .alu_flags_i (alu_flags_i),
    .rd_data_o   (rd_data_o),
    .flag_vec_o  (flag_vec_o),
    .sys_q       (sys_q)
);

// File: tb/test_cpu_status_flags.sv
module test_cpu_status_flags;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  mode = 2'b10;
    logic        priv = 1'b0;
    logic        sw_we = 1'b0;
    logic [63:0] wdata = '0;
    logic [6:0]  alu_en = '0;
    logic [6:0]  alu_val = '0;
    logic [63:0] rd;
    logic [6:0]  fv;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 0;

    // Behavioural model: architectural low half-word and system half-word.
    logic [15:0] m_low = 16'h0002;
    logic [15:0] m_sys = 16'h0000;
    int fpos[7] = '{0, 2, 4, 6, 7, 10, 11};

    always #5 clk = ~clk;

    cpu_status_flags i_cpu_status_flags (
        .clk         (clk),
        .rst         (rst),
        .mode_i      (mode),
        .priv_i      (priv),
        .sw_we_i     (sw_we),
        .sw_wdata_i  (wdata),
        .alu_en_i    (alu_en),
        .alu_flags_i (alu_val),
        .rd_data_o   (rd),
        .flag_vec_o  (fv)
    );

    task automatic model_edge();
        if (rst) begin
            m_low = 16'h0002;
            m_sys = 16'h0000;
        end else if (sw_we) begin
            m_low = (wdata[15:0] & 16'h0CD5) | 16'h0002;
            if (priv && mode != 2'b00) m_sys = wdata[31:16];
        end else begin
            for (int i = 0; i < 7; i++)
                if (alu_en[i]) m_low[fpos[i]] = alu_val[i];
        end
    endtask

    task automatic compare(input string tag);
        logic [63:0] e_rd;
        logic [6:0]  e_fv;
        e_rd = (mode == 2'b00) ? {48'd0, m_low} : {32'd0, m_sys, m_low};
        for (int i = 0; i < 7; i++) e_fv[i] = m_low[fpos[i]];
        n_cmp++;
        if (rd !== e_rd || fv !== e_fv) begin
            n_bad++;
            $display("FAIL %s: actual rd=%h flags=%b expected rd=%h flags=%b",
                     tag, rd, fv, e_rd, e_fv);
        end
    endtask

    // Called at a falling edge: drive, take one rising edge, compare at the next falling edge.
    task automatic step(input string tag, input logic [1:0] md, input logic pv,
                        input logic we, input logic [63:0] d,
                        input logic [6:0] en, input logic [6:0] v);
        mode = md; priv = pv; sw_we = we; wdata = d; alu_en = en; alu_val = v;
        @(posedge clk);
        model_edge();
        @(negedge clk);
        compare(tag);
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        #2000000;
        n_bad++;
        $display("FAIL watchdog (R10): actual=run hung expected=run complete");
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R2: reset state seen in every view (R5)
        step("R2 reset 64-bit view", 2'b10, 0, 0, 64'd0, 7'd0, 7'd0);
        step("R2 R5 reset 16-bit view", 2'b00, 0, 0, 64'd0, 7'd0, 7'd0);
        step("R2 R5 reset 32-bit view", 2'b01, 0, 0, 64'd0, 7'd0, 7'd0);
        // R3 R4 R7: privileged all-ones write in full view
        step("R3 R4 R7 priv all-ones", 2'b10, 1, 1, '1, 7'd0, 7'd0);
        step("R5 16-bit view of all-ones", 2'b00, 0, 0, 64'd0, 7'd0, 7'd0);
        step("R5 mode 11 full view", 2'b11, 0, 0, 64'd0, 7'd0, 7'd0);
        // R7: unprivileged zero write clears flags only
        step("R7 unpriv zero write", 2'b10, 0, 1, 64'd0, 7'd0, 7'd0);
        step("R7 readback 32-bit", 2'b01, 0, 0, 64'd0, 7'd0, 7'd0);
        // R6: privileged write in 16-bit view keeps the system half
        step("R6 priv write narrow", 2'b00, 1, 1, 64'h0000_0000_0000_0801, 7'd0, 7'd0);
        step("R6 readback 32-bit", 2'b01, 0, 0, 64'd0, 7'd0, 7'd0);
        // R7: privileged write in 32-bit view changes it
        step("R7 priv write 32-bit", 2'b01, 1, 1, 64'hFFFF_FFFF_1234_0400, 7'd0, 7'd0);
        // R8 R10: walking single enables, value one then zero
        for (int i = 0; i < 7; i++)
            step("R8 R10 walking set", 2'b10, 0, 0, 64'd0, 7'(1 << i), 7'h7F);
        for (int i = 0; i < 7; i++)
            step("R8 walking clear", 2'b01, 0, 0, 64'd0, 7'(1 << i), 7'h00);
        step("R8 masked update holds", 2'b10, 0, 0, 64'd0, 7'd0, 7'h7F);
        step("R8 group update", 2'b10, 0, 0, 64'd0, 7'b1010101, 7'b1111111);
        // R9: software write beats simultaneous execution-unit update
        step("R9 sw over alu zeros", 2'b10, 0, 1, 64'd0, 7'h7F, 7'h7F);
        step("R9 sw over alu ones", 2'b00, 0, 1, 64'h0000_0000_0000_0CD5, 7'h7F, 7'h00);
        // R1: single flag placement via software write
        for (int i = 0; i < 7; i++)
            step("R1 flag position", 2'b10, 0, 1, 64'(1) << fpos[i], 7'd0, 7'd0);
        // R3: reserved data only
        step("R3 reserved-only write", 2'b10, 1, 1, 64'hFFFF_FFFF_0000_0000, 7'd0, 7'd0);
        // Mixed traffic, checked every cycle (R8 R9 R6 R7)
        for (int k = 0; k < 400; k++)
            step("R8 R9 R7 mixed", 2'($urandom), 1'($urandom), ($urandom % 4) == 0,
                 {$urandom, $urandom}, 7'($urandom), 7'($urandom));
        // R2: reset again mid-run
        rst = 1'b1;
        step("R2 reset pulse", 2'b10, 0, 0, 64'd0, 7'd0, 7'd0);
        rst = 1'b0;
        step("R2 after second reset", 2'b01, 0, 0, 64'd0, 7'd0, 7'd0);
        summary();
    end

endmodule